// File: doc/BRIEF.md
# Successive-Integration Conversion Sequencer

This block is the digital core of a high-resolution integrating converter. It steps the analog front end through a fixed measurement sequence. A zero-integrate settle comes first, then a timed input integration. Three de-integrate passes follow, separated by rest and times-ten residue amplification intervals. Each pass refines the previous one by one decade. Throughout, a six-decade BCD up/down counter accumulates the reading. The counter steps at a weight of hundreds, then tens, then units. Its count direction reverses between passes, because each pass measures the overshoot or undershoot that the previous one left behind.

Each conversion runs the whole sequence twice. The first run measures the real input. The second run closes the offset-integrate switch instead, so the inputs are shorted. In the second run every count direction is inverted, so the offset reading is subtracted from the input reading in the same counter. No separate subtractor is needed. When the second run ends, the corrected value is copied into a result register and a one-clock done strobe is raised.

The analog parts are outside the block. The comparator reports the integrator zero crossing on one input. A second input reports the input polarity. A range bit selects the long or the short integration window. A clock-enable input sets the converter clock rate, which is one step per two oscillator periods.

Top module: `sint_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, `sw_ctl` is 7'b0000001 (zero-integrate), `done` is 0, and `result_bcd` and `result_neg` are 0.
- R2: The switch bits are: bit0 zero-integrate, bit1 input-integrate, bit2 offset-integrate, bit3 de-integrate positive, bit4 de-integrate negative, bit5 rest, bit6 times-ten. At most one bit is high. Each run follows the order zero-integrate, integrate, DE1, rest, times-ten, DE2, rest, times-ten, DE3. The first run uses bit1 and the second run uses bit2. After the second run all bits are low for one enabled cycle, and then the next conversion begins.
- R3: The integrate phase lasts exactly `INT_LO` enabled clocks when `range_hi` was 0, and `INT_HI` enabled clocks when it was 1. `range_hi` is sampled as zero-integrate ends. Zero-integrate lasts `ZI_CYC` enabled clocks. Each rest and times-ten phase lasts `SETTLE_CYC` enabled clocks.
- R4: On each enabled clock of a de-integrate phase in which `cmp_zero` is 0, the counter steps once. The step is +100 in DE1, −10 in DE2 and +1 in DE3. For a positive first run, the counter therefore holds 100·a − 10·b + c.
- R5: An enabled clock in a de-integrate phase with `cmp_zero` high ends that phase and leaves the counter unchanged.
- R6: A de-integrate phase ends after `DE_MAX` steps even if `cmp_zero` stays low.
- R7: `in_neg` is sampled as integrate ends. If it is 0, bit3 drives the de-integrate phases of that run. If it is 1, bit4 drives them and all step directions of that run are inverted.
- R8: In the second (shorted-input) run all step directions are inverted again. The final value is therefore the first run's signed reading minus the second run's signed reading.
- R9: `done` is high for exactly one clock per conversion. `result_bcd` changes only on that clock and then holds the corrected value.
- R10: While `clk_en` is 0, `sw_ctl`, the timers and the counter do not change.
- R11: `result_bcd` holds six BCD digits in ten's complement modulo 10^6, with the digit for the units in bits [3:0]. `result_neg` is 1 exactly when the top digit is 5 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Converter clock enable (one per two oscillator periods) |
| cmp_zero | input | 1 | Integrator zero-crossing comparator |
| in_neg | input | 1 | Input polarity, 1 = negative |
| range_hi | input | 1 | 1 selects the short integration window |
| sw_ctl | output | 7 | One-hot analog switch controls |
| result_bcd | output | 24 | Corrected six-decade reading, ten's complement BCD |
| result_neg | output | 1 | Sign of the reading |
| done | output | 1 | One-clock strobe when the result updates |

## Verification
A corrupted phase register appears on `sw_ctl` at the next enabled clock, as a switch out of order or as two switches at once. A wrong timer appears as an integrate or settle phase of the wrong length in that same conversion. Counter faults, such as a wrong weight, direction, polarity inversion or offset subtraction, are visible only at the next `done`, up to one full conversion later. The bench therefore checks every conversion's result against a value built from the comparator stop points it chose itself.

// File: rtl/sint_pkg.sv
package sint_pkg;

    localparam int NDIG = 6;
    localparam int SW_W = 7;

    localparam int SW_ZI   = 0;
    localparam int SW_INT1 = 1;
    localparam int SW_INT2 = 2;
    localparam int SW_DEP  = 3;
    localparam int SW_DEN  = 4;
    localparam int SW_REST = 5;
    localparam int SW_X10  = 6;

    typedef enum logic [3:0] {
        PH_ZI, PH_INT, PH_DE1, PH_RST1, PH_X1,
        PH_DE2, PH_RST2, PH_X2, PH_DE3, PH_DONE
    } phase_e;

    typedef struct packed {
        logic       step;
        logic       down;
        logic [1:0] wsel;   // decade receiving the step: 0 units, 1 tens, 2 hundreds
        logic       clr;
    } cnt_cmd_t;

    function automatic logic is_deint(phase_e p);
        return (p == PH_DE1) || (p == PH_DE2) || (p == PH_DE3);
    endfunction

    function automatic phase_e phase_after(phase_e p, logic second_run);
        case (p)
            PH_ZI:   return PH_INT;
            PH_INT:  return PH_DE1;
            PH_DE1:  return PH_RST1;
            PH_RST1: return PH_X1;
            PH_X1:   return PH_DE2;
            PH_DE2:  return PH_RST2;
            PH_RST2: return PH_X2;
            PH_X2:   return PH_DE3;
            PH_DE3:  return second_run ? PH_DONE : PH_ZI;
            default: return PH_ZI;
        endcase
    endfunction

    function automatic logic [3:0] bcd_adj(logic [3:0] d, logic down);
        if (down) return (d == 4'd0) ? 4'd9 : d - 4'd1;
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/sint_bcd_ctr.sv
module sint_bcd_ctr
    import sint_pkg::*;
#(
    parameter int DIGITS = NDIG
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cnt_cmd_t              cmd,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS:0]     carry;
    logic [4*DIGITS-1:0] nxt;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
        logic [3:0] d;
        logic       cin;
        assign d   = value[4*i +: 4];
        assign cin = cmd.step && ((i == int'(cmd.wsel)) || carry[i]);
        assign carry[i+1] = cin && (cmd.down ? (d == 4'd0) : (d == 4'd9));
        assign nxt[4*i +: 4] = cin ? bcd_adj(d, cmd.down) : d;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) value <= '0;
        else if (cmd.step)  value <= nxt;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.step && !cmd.clr) |=> $stable(value)); // R10

endmodule

// File: rtl/sint_phase_fsm.sv
module sint_phase_fsm
    import sint_pkg::*;
#(
    parameter int INT_LO     = 10000,
    parameter int INT_HI     = 1000,
    parameter int ZI_CYC     = 100,
    parameter int SETTLE_CYC = 50,
    parameter int DE_MAX     = 4000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_en,
    input  logic     cmp_zero,
    input  logic     in_neg,
    input  logic     range_hi,
    output phase_e   ph,
    output logic     second_run,
    output logic     pol_neg,
    output cnt_cmd_t cmd,
    output logic     done_o
);
    localparam int M1     = (INT_LO > INT_HI) ? INT_LO : INT_HI;
    localparam int M2     = (ZI_CYC > SETTLE_CYC) ? ZI_CYC : SETTLE_CYC;
    localparam int M3     = (M1 > M2) ? M1 : M2;
    localparam int LIM_MX = (M3 > DE_MAX) ? M3 : DE_MAX;
    localparam int TW     = $clog2(LIM_MX + 1);

    logic [TW-1:0] tmr;
    logic [TW-1:0] lim;
    logic          rng_q;
    logic          de_now;
    logic          leave;

    assign de_now = is_deint(ph);

    always_comb begin
        case (ph)
            PH_ZI:                     lim = TW'(ZI_CYC);
            PH_INT:                    lim = rng_q ? TW'(INT_HI) : TW'(INT_LO);
            PH_DE1, PH_DE2, PH_DE3:    lim = TW'(DE_MAX);
            PH_DONE:                   lim = TW'(1);
            default:                   lim = TW'(SETTLE_CYC);
        endcase
        leave = (tmr == lim - 1'b1) || (de_now && cmp_zero);

        cmd.step = clk_en && de_now && !cmp_zero;
        cmd.down = (ph == PH_DE2) ^ pol_neg ^ second_run;
        cmd.clr  = clk_en && (ph == PH_DONE);
        case (ph)
            PH_DE1:  cmd.wsel = 2'd2;
            PH_DE2:  cmd.wsel = 2'd1;
            default: cmd.wsel = 2'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_ZI;
            tmr        <= '0;
            rng_q      <= 1'b0;
            pol_neg    <= 1'b0;
            second_run <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (clk_en) begin
                if (leave) begin
                    tmr <= '0;
                    ph  <= phase_after(ph, second_run);
                    case (ph)
                        PH_ZI:   rng_q   <= range_hi;
                        PH_INT:  pol_neg <= in_neg;
                        PH_DE3:  second_run <= 1'b1;
                        PH_DONE: begin
                            second_run <= 1'b0;
                            done_o     <= 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(ph) && $stable(tmr))); // R10

endmodule

// File: rtl/sint_switch_dec.sv
module sint_switch_dec
    import sint_pkg::*;
(
    input  phase_e          ph,
    input  logic            second_run,
    input  logic            pol_neg,
    output logic [SW_W-1:0] sw
);
    always_comb begin
        sw = '0;
        case (ph)
            PH_ZI:                  sw[SW_ZI] = 1'b1;
            PH_INT:                 sw[second_run ? SW_INT2 : SW_INT1] = 1'b1;
            PH_DE1, PH_DE2, PH_DE3: sw[pol_neg ? SW_DEN : SW_DEP] = 1'b1;
            PH_RST1, PH_RST2:       sw[SW_REST] = 1'b1;
            PH_X1, PH_X2:           sw[SW_X10] = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sint_sequencer.sv
module sint_sequencer
    import sint_pkg::*;
#(
    parameter int DIGITS     = NDIG,
    parameter int INT_LO     = 10000,
    parameter int INT_HI     = 1000,
    parameter int ZI_CYC     = 100,
    parameter int SETTLE_CYC = 50,
    parameter int DE_MAX     = 4000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                cmp_zero,
    input  logic                in_neg,
    input  logic                range_hi,
    output logic [SW_W-1:0]     sw_ctl,
    output logic [4*DIGITS-1:0] result_bcd,
    output logic                result_neg,
    output logic                done
);
    localparam int RW = $clog2(DE_MAX + 2);

    phase_e              ph;
    logic                second_run;
    logic                pol_neg;
    cnt_cmd_t            cmd;
    logic [4*DIGITS-1:0] cnt_val;
    logic [4*DIGITS-1:0] result_q;

    sint_phase_fsm #(
        .INT_LO(INT_LO), .INT_HI(INT_HI), .ZI_CYC(ZI_CYC),
        .SETTLE_CYC(SETTLE_CYC), .DE_MAX(DE_MAX)
    ) u_fsm (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cmp_zero(cmp_zero),
        .in_neg(in_neg), .range_hi(range_hi), .ph(ph),
        .second_run(second_run), .pol_neg(pol_neg), .cmd(cmd), .done_o(done)
    );

    sint_bcd_ctr #(.DIGITS(DIGITS)) u_ctr (
        .clk(clk), .rst(rst), .cmd(cmd), .value(cnt_val)
    );

    sint_switch_dec u_dec (
        .ph(ph), .second_run(second_run), .pol_neg(pol_neg), .sw(sw_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst)          result_q <= '0;
        else if (cmd.clr) result_q <= cnt_val;
    end

    assign result_bcd = result_q;
    assign result_neg = (result_q[4*DIGITS-1 -: 4] >= 4'd5);

    // checker: steps taken in the current de-integrate phase
    logic [RW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst || !is_deint(ph))         run_cnt <= '0;
        else if (clk_en && !cmp_zero)     run_cnt <= run_cnt + 1'b1;
    end

    AST_SW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_ctl)); // R2

    AST_CROSS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clk_en && cmp_zero && (sw_ctl[SW_DEP] || sw_ctl[SW_DEN])) |=> $stable(cnt_val)); // R5

    AST_DE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RW'(DE_MAX)); // R6

    AST_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_val == '0)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result_bcd)); // R9

endmodule

// File: tb/sint_sequencer_tb.sv
module sint_sequencer_tb_top;

    localparam int INT_LO = 40;
    localparam int INT_HI = 8;
    localparam int ZI_CYC = 4;
    localparam int SETTLE = 3;
    localparam int DE_MAX = 30;
    localparam int NCONV  = 24;
    localparam int WD     = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        cmp_zero = 1'b0;
    logic        in_neg = 1'b0;
    logic        range_hi = 1'b0;
    logic [6:0]  sw_ctl;
    logic [23:0] result_bcd;
    logic        result_neg;
    logic        done;

    always #5 clk = ~clk;

    sint_sequencer #(
        .INT_LO(INT_LO), .INT_HI(INT_HI), .ZI_CYC(ZI_CYC),
        .SETTLE_CYC(SETTLE), .DE_MAX(DE_MAX)
    ) dut_i (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cmp_zero(cmp_zero),
        .in_neg(in_neg), .range_hi(range_hi), .sw_ctl(sw_ctl),
        .result_bcd(result_bcd), .result_neg(result_neg), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] to_tc(input int v);
        int u;
        logic [23:0] r;
        u = v % 1000000;
        if (u < 0) u += 1000000;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(u % 10);
            u = u / 10;
        end
        return r;
    endfunction

    function automatic int clampd(input int t);
        return (t < DE_MAX) ? t : DE_MAX;
    endfunction

    // expected switch pattern at sequence position 0..18 (18 = all off)
    function automatic logic [6:0] exp_sw(input int pos, input bit p1, input bit p2);
        int p;
        bit pol;
        if (pos == 18) return 7'h00;
        p   = pos % 9;
        pol = (pos >= 9) ? p2 : p1;
        case (p)
            0:       return 7'h01;
            1:       return (pos >= 9) ? 7'h04 : 7'h02;
            2, 5, 8: return pol ? 7'h10 : 7'h08;
            3, 6:    return 7'h20;
            default: return 7'h40;
        endcase
    endfunction

    int          conv_idx = -1;
    int          tgt [6];
    bit          pol1, pol2, rng;
    logic [23:0] exp_res;
    int          pos = 0;
    int          ndone = 0;
    int          den = 0;
    int          int_cnt = 0;
    int          hold_left = 0;
    logic [6:0]  hold_sw;
    logic [23:0] hold_res;
    logic [6:0]  prev_sw = 7'h01;
    bit          en_q = 1'b0;
    bit          cmp_q = 1'b0;
    bit          prev_done = 1'b0;

    task automatic new_conv();
        int v1, v2;
        conv_idx++;
        pol1 = 1'b0; pol2 = 1'b0; rng = 1'b0;
        case (conv_idx)
            0: tgt = '{0, 0, 0, 0, 0, 0};                         // R5 immediate crossings
            1: tgt = '{DE_MAX + 5, 3, 2, 1, 0, 0};                // R6 timeout in DE1
            2: begin tgt = '{5, 4, 3, 0, 0, 1}; pol1 = 1'b1; end  // R7 negative input, R11 sign
            3: begin tgt = '{7, 2, 9, 0, 1, 2}; rng = 1'b1; end   // R3 short window, R10 hold
            default: begin
                for (int i = 0; i < 6; i++) tgt[i] = int'($urandom % (DE_MAX + 3));
                pol1 = 1'($urandom);
                pol2 = 1'($urandom);
                rng  = 1'($urandom);
            end
        endcase
        v1 = 100 * clampd(tgt[0]) - 10 * clampd(tgt[1]) + clampd(tgt[2]);
        v2 = 100 * clampd(tgt[3]) - 10 * clampd(tgt[4]) + clampd(tgt[5]);
        if (pol1) v1 = -v1;
        if (pol2) v2 = -v2;
        exp_res  = to_tc(v1 - v2);   // R8 offset run subtracted
        in_neg   = pol1;
        range_hi = rng;
    endtask

    function automatic bit is_de(input logic [6:0] s);
        return s[3] || s[4];
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            prev_sw  = 7'h01;
            en_q     = clk_en;
            cmp_q    = 1'b0;
            cmp_zero = 1'b0;
        end else begin
            // effects of the last posedge
            if (prev_sw[1] || prev_sw[2]) begin
                if (en_q) int_cnt++;
            end
            if (is_de(prev_sw) && en_q && !cmp_q) den++;

            if (hold_left > 0) begin
                chk(sw_ctl == hold_sw && result_bcd == hold_res && !done,
                    "R10 frozen while clk_en low", {sw_ctl, result_bcd}, {hold_sw, hold_res});
                hold_left--;
            end

            if (done) begin
                ndone++;
                chk(result_bcd == exp_res, "R4 R8 R11 corrected result", result_bcd, exp_res);
                chk(result_neg == exp_res[23:20] >= 4'd5, "R11 sign flag", result_neg, exp_res[23:20] >= 4'd5);
                chk(!prev_done && pos == 18, "R9 single done at end of second run", {prev_done, 5'(pos)}, 18);
            end

            if (sw_ctl != prev_sw) begin
                if (prev_sw[1] || prev_sw[2])
                    chk(int_cnt == (rng ? INT_HI : INT_LO), "R3 integrate length",
                        int_cnt, rng ? INT_HI : INT_LO);
                pos = (pos == 18) ? 0 : pos + 1;
                if (pos == 0) new_conv();
                if (pos == 9) in_neg = pol2;
                chk(sw_ctl == exp_sw(pos, pol1, pol2), "R2 R7 switch sequence",
                    sw_ctl, exp_sw(pos, pol1, pol2));
                if (sw_ctl[1] || sw_ctl[2]) int_cnt = 0;
                if (is_de(sw_ctl)) den = 0;
                if (conv_idx == 3 && pos == 5 && hold_left == 0) begin
                    hold_left = 12;
                    hold_sw   = sw_ctl;
                    hold_res  = result_bcd;
                end
            end

            if (is_de(sw_ctl)) begin
                int slot;
                slot = ((pos % 9) == 2) ? 0 : ((pos % 9) == 5) ? 1 : 2;
                if (pos >= 9) slot += 3;
                cmp_zero = (den >= tgt[slot]);
            end else begin
                cmp_zero = 1'b0;
            end

            clk_en    = (hold_left > 0) ? 1'b0 : (($urandom % 4) != 0);
            prev_sw   = sw_ctl;
            en_q      = clk_en;
            cmp_q     = cmp_zero;
        end
        prev_done = done;
    end

    initial begin
        void'($urandom(32'd20240607));
        new_conv();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sw_ctl == 7'h01 && !done && result_bcd == 24'h0 && !result_neg,
            "R1 reset state", {sw_ctl, result_bcd}, {7'h01, 24'h0});
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(sw_ctl == 7'h01 && result_bcd == 24'h0, "R1 first cycle after reset",
            {sw_ctl, result_bcd}, {7'h01, 24'h0});
        while (ndone < NCONV && cyc < WD) @(negedge clk);
        if (cyc >= WD) chk(1'b0, "watchdog expired", cyc, WD);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule